// File: doc/BRIEF.md
# Serial EEPROM Write Command Controller

This block is the write path on the device side of a serial EEPROM that sits on an SPI bus. It watches the bus for the write opcode and takes in a 24-bit address followed by any number of data bytes. The bytes are gathered in a 256-entry page buffer. When chip select is released after at least one complete data byte, the block starts an internal programming cycle. The busy period lasts a fixed, parameterised number of system clocks. During that period the buffered bytes are written to the memory array port, and every command except the status read is turned away.

The bus pins are oversampled by the system clock in SPI mode 0: data is taken on the rising edge of SCK, most significant bit first. The controller reads the write-enable latch from its own register, which a neighbouring decoder sets with a one-cycle pulse. The controller clears that latch itself when a programming cycle ends. Write-protect level, identification-page select and identification-page lock arrive as status inputs. When identification-page select is set, the same write sequence is aimed at a separate 256-byte page, with lock and protection rules. Opcodes the block does not handle are passed to neighbouring decoders as a one-cycle pulse.

Top module: `wr_cmd_ctl`

## Requirements
- R1: The write opcode is 0x02, shifted in MSB first and sampled on rising SCK. It is acted on only when `wel` is 1. With `wel` at 0 the whole transaction is ignored and no cycle starts.
- R2: The opcode is followed by three address bytes, MSB first. For the main array only A16..A0 reach `mem_addr`, and A23..A17 have no effect.
- R3: Each later data byte goes to the next byte offset. The page bits A16..A8 stay fixed and the offset wraps from 0xFF to 0x00. A byte loaded later to the same offset replaces the earlier one, so each location is written once with its last value.
- R4: A programming cycle starts when CS_n rises after one or more whole data bytes. During the cycle every loaded location is written exactly once on `mem_we`, in ascending order of byte offset.
- R5: The write is aborted if CS_n rises after the address with no data byte, or in the middle of a data byte. No cycle starts, nothing is written and `wel` stays 1.
- R6: `rdy` is 1 for exactly WRITE_CYCLES clocks. It rises on the 4th rising clock edge after the rise of CS_n that starts the cycle: two synchroniser stages, one edge stage and one start register.
- R7: While `rdy` is 1, only opcode 0x05 is acted on, and it is forwarded on `cmd_vld`/`cmd_op`. Any other opcode is dropped together with the rest of its transaction, a complete write sequence included.
- R8: `wel` returns to 0 on the same clock edge on which `rdy` falls.
- R9: With `ipl`=1 the write targets the identification page. `mem_id` is 1, A7..A0 give the offset, A23..A8 are ignored, and the upper `mem_addr` bits are 0.
- R10: An identification-page write is rejected, with `wel` kept at 1, when `lip`=1 or `bp`=2'b11.
- R11: An identification-page write is also rejected when its start offset lies in the protected region: offsets 0xC0..0xFF for `bp`=2'b01 and 0x80..0xFF for `bp`=2'b10. Only the start offset is checked.
- R12: When not busy, any opcode other than 0x02 gives one `cmd_vld` pulse carrying that opcode. A `wel_set` pulse while not busy sets `wel` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in |
| wel_set | input | 1 | Pulse from the write-enable decoder |
| ipl | input | 1 | Status: route writes to the identification page |
| lip | input | 1 | Status: identification page locked |
| bp | input | 2 | Status: block-protect level |
| wel | output | 1 | Write-enable latch |
| rdy | output | 1 | Internal write in progress (1 = busy) |
| cmd_vld | output | 1 | Forwarded opcode strobe |
| cmd_op | output | 8 | Forwarded opcode |
| mem_we | output | 1 | Array write strobe |
| mem_id | output | 1 | Write targets the identification page |
| mem_addr | output | MAIN_AW | Array byte address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench goes after the wrap-around of the offset within a page, including a load of more than 256 bytes. A design that carried into the page bits, or that committed stale bytes twice, would show wrong addresses or data in the commit order. It aborts writes on a partial byte and on an empty data phase; a design that counted bits wrongly would start a cycle and drop `wel`. It sends status reads, other opcodes and a full write during the busy window, where leaking gating would forward the wrong opcode or queue a second commit. It also tests the protection boundaries of the identification page one offset either side, where an off-by-one region test would accept or reject the wrong start offset.

// File: rtl/wr_ctl_pkg.sv
package wr_ctl_pkg;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam int ADDR_BYTES       = 3;
    localparam int OFS_W            = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic bit_stb,
    output logic bit_val,
    output logic cs_fall,
    output logic cs_rise
);
    localparam int CW = SYNC_STAGES * 3;

    typedef struct packed {
        logic [CW-1:0] chain;
        logic [1:0]    last;
    } sync_t;

    sync_t q, d;
    logic [2:0] synced;

    assign synced = q.chain[CW-1 -: 3];

    always_comb begin
        d       = q;
        d.chain = {q.chain[CW-4:0], sck, cs_n, mosi};
        d.last  = synced[2:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.chain <= {SYNC_STAGES{3'b010}};
            q.last  <= 2'b01;
        end else begin
            q <= d;
        end
    end

    assign bit_stb = synced[2] & ~q.last[1] & ~synced[1];
    assign bit_val = synced[0];
    assign cs_rise = synced[1] & ~q.last[0];
    assign cs_fall = ~synced[1] & q.last[0];
endmodule

// File: rtl/wr_seq_fsm.sv
module wr_seq_fsm
    import wr_ctl_pkg::*;
#(
    parameter int MAIN_AW = 17
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_stb,
    input  logic                   bit_val,
    input  logic                   cs_fall,
    input  logic                   cs_rise,
    input  logic                   busy,
    input  logic                   wel,
    input  logic                   ipl,
    input  logic                   lip,
    input  logic [1:0]             bp,
    output logic                   load_vld,
    output logic [OFS_W-1:0]       load_idx,
    output logic [7:0]             load_data,
    output logic                   buf_clr,
    output logic                   start,
    output logic                   tgt_id,
    output logic [MAIN_AW-OFS_W-1:0] page,
    output logic                   fwd_vld,
    output logic [7:0]             fwd_op
);
    localparam int PAGE_W = MAIN_AW - OFS_W;
    localparam int AB_W   = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        bitcnt;
        logic [6:0]        shreg;
        logic [AB_W-1:0]   abytes;
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ptr;
        logic              got;
        logic              tgt_id;
        logic              start;
        logic              load_vld;
        logic [OFS_W-1:0]  load_idx;
        logic [7:0]        load_data;
        logic              clr;
        logic              fwd_vld;
        logic [7:0]        fwd_op;
    } seq_t;

    seq_t q, d;
    logic [7:0] byte_now;
    logic       byte_done;

    assign byte_now  = {q.shreg, bit_val};
    assign byte_done = bit_stb && (q.bitcnt == 3'd7);

    function automatic logic in_prot(input logic [OFS_W-1:0] ofs, input logic [1:0] lvl);
        case (lvl)
            2'b01:   in_prot = (ofs[OFS_W-1:OFS_W-2] == 2'b11);
            2'b10:   in_prot = ofs[OFS_W-1];
            2'b11:   in_prot = 1'b1;
            default: in_prot = 1'b0;
        endcase
    endfunction

    always_comb begin
        d          = q;
        d.start    = 1'b0;
        d.load_vld = 1'b0;
        d.clr      = 1'b0;
        d.fwd_vld  = 1'b0;
        if (cs_fall) begin
            d.phase  = PH_OPC;
            d.bitcnt = '0;
            d.abytes = '0;
            d.got    = 1'b0;
        end else if (cs_rise) begin
            if (q.phase == PH_DATA && q.bitcnt == 3'd0 && q.got) begin
                d.start = 1'b1;
            end
            d.phase = PH_IDLE;
        end else if (bit_stb && q.phase != PH_IDLE) begin
            d.shreg  = byte_now[6:0];
            d.bitcnt = q.bitcnt + 3'd1;
            if (byte_done) begin
                case (q.phase)
                    PH_OPC: begin
                        d.phase = PH_SKIP;
                        if (busy) begin
                            if (byte_now == OP_RDSR) begin
                                d.fwd_vld = 1'b1;
                                d.fwd_op  = byte_now;
                            end
                        end else if (byte_now == OP_WRITE) begin
                            if (wel) d.phase = PH_ADDR;
                        end else begin
                            d.fwd_vld = 1'b1;
                            d.fwd_op  = byte_now;
                        end
                    end
                    PH_ADDR: begin
                        d.abytes = q.abytes + 1'b1;
                        if (q.abytes == AB_W'(ADDR_BYTES - 1)) begin
                            if (ipl && (lip || in_prot(byte_now, bp))) begin
                                d.phase = PH_SKIP;
                            end else begin
                                d.phase  = PH_DATA;
                                d.ptr    = byte_now;
                                d.tgt_id = ipl;
                                d.clr    = 1'b1;
                            end
                        end else begin
                            d.page = PAGE_W'({q.page, byte_now});
                        end
                    end
                    PH_DATA: begin
                        d.load_vld  = 1'b1;
                        d.load_idx  = q.ptr;
                        d.load_data = byte_now;
                        d.ptr       = q.ptr + 1'b1;
                        d.got       = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign load_vld  = q.load_vld;
    assign load_idx  = q.load_idx;
    assign load_data = q.load_data;
    assign buf_clr   = q.clr;
    assign start     = q.start;
    assign tgt_id    = q.tgt_id;
    assign page      = q.page;
    assign fwd_vld   = q.fwd_vld;
    assign fwd_op    = q.fwd_op;

    // R7: while busy only the status read may be forwarded
    a_r7_busy_fwd_rdsr: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fwd_vld && busy) |-> (q.fwd_op == OP_RDSR));

    // R10: an accepted identification-page write never sees a lock or full protection
    a_r10_id_accept_rules: assert property (@(posedge clk) disable iff (!rst_n)
        (q.clr && q.tgt_id) |-> (!$past(lip) && $past(bp) != 2'b11));
endmodule

// File: rtl/wr_page_buf.sv
module wr_page_buf
    import wr_ctl_pkg::*;
#(
    parameter int MAIN_AW = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     load_vld,
    input  logic [OFS_W-1:0]         load_idx,
    input  logic [7:0]               load_data,
    input  logic                     commit,
    input  logic                     tgt_id,
    input  logic [MAIN_AW-OFS_W-1:0] page,
    output logic                     mem_we,
    output logic                     mem_id,
    output logic [MAIN_AW-1:0]       mem_addr,
    output logic [7:0]               mem_wdata
);
    localparam int DEPTH  = 2 ** OFS_W;
    localparam int PAGE_W = MAIN_AW - OFS_W;

    typedef struct packed {
        logic [DEPTH-1:0]   vld;
        logic               walk;
        logic [OFS_W-1:0]   idx;
        logic               we;
        logic               id;
        logic [MAIN_AW-1:0] addr;
        logic [7:0]         wdata;
    } buf_t;

    buf_t q, d;
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (load_vld) store[load_idx] <= load_data;
    end

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (clr) d.vld = '0;
        if (load_vld) d.vld[load_idx] = 1'b1;
        if (commit) begin
            d.walk = 1'b1;
            d.idx  = '0;
        end else if (q.walk) begin
            if (q.vld[q.idx]) begin
                d.we    = 1'b1;
                d.id    = tgt_id;
                d.addr  = tgt_id ? {{PAGE_W{1'b0}}, q.idx} : {page, q.idx};
                d.wdata = store[q.idx];
            end
            d.idx = q.idx + 1'b1;
            if (q.idx == OFS_W'(DEPTH - 1)) d.walk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_we    = q.we;
    assign mem_id    = q.id;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;

    // R4: the buffer is never loaded while its contents are being committed
    a_r4_no_load_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |-> !q.walk);

    // R4: array writes only come from the commit walk
    a_r4_we_from_walk: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> $past(q.walk));
endmodule

// File: rtl/wr_cmd_ctl.sv
module wr_cmd_ctl
    import wr_ctl_pkg::*;
#(
    parameter int WRITE_CYCLES = 600,
    parameter int MAIN_AW      = 17,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    input  logic               wel_set,
    input  logic               ipl,
    input  logic               lip,
    input  logic [1:0]         bp,
    output logic               wel,
    output logic               rdy,
    output logic               cmd_vld,
    output logic [7:0]         cmd_op,
    output logic               mem_we,
    output logic               mem_id,
    output logic [MAIN_AW-1:0] mem_addr,
    output logic [7:0]         mem_wdata
);
    localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);
    localparam int PAGE_W = MAIN_AW - OFS_W;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             wel;
    } ctl_t;

    ctl_t q, d;

    logic              bit_stb, bit_val, cs_fall, cs_rise;
    logic              load_vld, buf_clr, start, tgt_id;
    logic [OFS_W-1:0]  load_idx;
    logic [7:0]        load_data;
    logic [PAGE_W-1:0] page;

    spi_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise)
    );

    wr_seq_fsm #(.MAIN_AW(MAIN_AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .busy      (q.busy),
        .wel       (q.wel),
        .ipl       (ipl),
        .lip       (lip),
        .bp        (bp),
        .load_vld  (load_vld),
        .load_idx  (load_idx),
        .load_data (load_data),
        .buf_clr   (buf_clr),
        .start     (start),
        .tgt_id    (tgt_id),
        .page      (page),
        .fwd_vld   (cmd_vld),
        .fwd_op    (cmd_op)
    );

    wr_page_buf #(.MAIN_AW(MAIN_AW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .load_vld  (load_vld),
        .load_idx  (load_idx),
        .load_data (load_data),
        .commit    (start),
        .tgt_id    (tgt_id),
        .page      (page),
        .mem_we    (mem_we),
        .mem_id    (mem_id),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    always_comb begin
        d = q;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(WRITE_CYCLES - 1);
        end else if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.wel  = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
        if (wel_set && !q.busy && !start) d.wel = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wel = q.wel;
    assign rdy = q.busy;

    // R1: a programming cycle only starts from an enabled, idle state
    a_r1_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.wel && !q.busy));

    // R8: the latch is down once the busy period ends
    a_r8_wel_drop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> !q.wel);
endmodule

// File: tb/sim_wr_cmd_ctl.sv
module sim_wr_cmd_ctl;
    localparam int W    = 600;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        wel_set = 1'b0, ipl = 1'b0, lip = 1'b0;
    logic [1:0]  bp = 2'b00;
    logic        wel, rdy, cmd_vld, mem_we, mem_id;
    logic [7:0]  cmd_op, mem_wdata;
    logic [16:0] mem_addr;

    always #4 clk = ~clk;

    wr_cmd_ctl #(.WRITE_CYCLES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .wel_set(wel_set), .ipl(ipl), .lip(lip), .bp(bp),
        .wel(wel), .rdy(rdy), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .mem_we(mem_we), .mem_id(mem_id), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int checks = 0, errors = 0;
    int ecount = 0;
    int busy_start = -1, busy_end = -1, wel_edge = -1;
    bit wel_m = 1'b0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    logic [7:0]  fwd_q[$];
    logic [7:0]  dq[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model timeline, advanced on every clock edge
    always @(posedge clk) begin
        ecount++;
        if (ecount == wel_edge) wel_m = 1'b1;
        if (ecount == busy_end) wel_m = 1'b0;
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rdy == ((ecount >= busy_start) && (ecount < busy_end)), "R6 rdy", {31'b0, rdy},
                {31'b0, ((ecount >= busy_start) && (ecount < busy_end))});
            chk(wel == wel_m, "R8/R12 wel", {31'b0, wel}, {31'b0, wel_m});
            if (mem_we) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write", {6'b0, mem_id, mem_addr, mem_wdata}, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk({6'b0, mem_id, mem_addr, mem_wdata} == e, "R2/R3/R4/R9 write", {6'b0, mem_id, mem_addr, mem_wdata}, e);
                end
            end
            if (cmd_vld) begin
                if (fwd_q.size() == 0) chk(1'b0, "R7 unexpected forward", {24'b0, cmd_op}, 32'h0);
                else begin
                    logic [7:0] f;
                    f = fwd_q.pop_front();
                    chk(cmd_op == f, "R7/R12 forward", {24'b0, cmd_op}, {24'b0, f});
                end
            end
        end
    end

    task automatic spi_byte(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk) mosi = b[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high(input bit cycle);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        if (cycle) begin
            busy_start = ecount + 4;
            busy_end   = busy_start + W;
        end
        repeat (HALF * 2) @(negedge clk);
    endtask

    task automatic set_wel();
        @(negedge clk) wel_set = 1'b1;
        wel_edge = ecount + 1;
        @(negedge clk) wel_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (ecount < busy_end + 2) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    function automatic bit rules_ok(input logic [23:0] a);
        if (!ipl) return 1'b1;
        if (lip) return 1'b0;
        case (bp)
            2'b00: return 1'b1;
            2'b01: return a[7:6] != 2'b11;
            2'b10: return !a[7];
            default: return 1'b0;
        endcase
    endfunction

    // sends a write with the bytes in dq and tail_bits of a partial byte
    task automatic do_write(input logic [23:0] a, input int tail_bits);
        bit busy_now, cycle;
        logic [7:0] img [256];
        bit v [256];
        logic [7:0] p;
        busy_now = (ecount < busy_end);
        cycle = wel_m && !busy_now && rules_ok(a) && dq.size() > 0 && tail_bits == 0;
        if (cycle) begin
            p = a[7:0];
            for (int i = 0; i < 256; i++) v[i] = 1'b0;
            foreach (dq[k]) begin
                img[p] = dq[k];
                v[p] = 1'b1;
                p = p + 8'd1;
            end
            for (int i = 0; i < 256; i++)
                if (v[i]) exp_q.push_back({6'b0, ipl, ipl ? {9'b0, 8'(i)} : {a[16:8], 8'(i)}, img[i]});
        end
        cs_low();
        spi_byte(8'h02, 8);
        spi_byte(a[23:16], 8);
        spi_byte(a[15:8], 8);
        spi_byte(a[7:0], 8);
        foreach (dq[k]) spi_byte(dq[k], 8);
        if (tail_bits > 0) spi_byte(8'hA5, tail_bits);
        cs_high(cycle);
    endtask

    task automatic do_cmd(input logic [7:0] op, input bit fwd);
        if (fwd) fwd_q.push_back(op);
        cs_low();
        spi_byte(op, 8);
        cs_high(1'b0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy == 1'b0 && wel == 1'b0 && mem_we == 1'b0, "R6/R8 reset state", {29'b0, rdy, wel, mem_we}, 32'h0);

        // R1: write without the enable latch is ignored
        dq = '{8'h11};
        do_write(24'h000100, 0);
        repeat (20) @(negedge clk);
        chk(rdy == 1'b0 && exp_q.size() == 0, "R1 no cycle without wel", {31'b0, rdy}, 32'h0);

        // R12: idle opcode forwarded
        do_cmd(8'h9F, 1'b1);

        // R2: top address bits are don't care
        set_wel();
        chk(wel == 1'b1, "R12 wel set", {31'b0, wel}, 32'h1);
        dq = '{8'h3C};
        do_write(24'hFE2345, 0);
        // R7: busy gating of commands and of a whole write
        do_cmd(8'h05, 1'b1);
        do_cmd(8'h9F, 1'b0);
        dq = '{8'h77};
        do_write(24'h000000, 0);
        wait_idle();
        chk(wel == 1'b0, "R8 wel cleared after cycle", {31'b0, wel}, 32'h0);

        // R3: wrap inside the page
        set_wel();
        dq = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5};
        do_write(24'h0001FC, 0);
        wait_idle();

        // R3: more than a page overwrites earliest bytes
        set_wel();
        dq.delete();
        for (int i = 0; i < 258; i++) dq.push_back(8'(i * 7 + 3));
        do_write(24'h013010, 0);
        wait_idle();

        // R5: partial byte and empty data phase abort
        set_wel();
        dq = '{8'h55};
        do_write(24'h000020, 3);
        repeat (20) @(negedge clk);
        chk(wel == 1'b1 && rdy == 1'b0, "R5 partial byte abort", {30'b0, wel, rdy}, 32'h2);
        dq.delete();
        do_write(24'h000020, 0);
        repeat (20) @(negedge clk);
        chk(wel == 1'b1 && rdy == 1'b0, "R5 empty data abort", {30'b0, wel, rdy}, 32'h2);

        // R9: identification page
        ipl = 1'b1;
        dq = '{8'hD1, 8'hD2};
        do_write(24'hFFFF05, 0);
        wait_idle();

        // R10: lock and full protection reject
        set_wel();
        lip = 1'b1;
        dq = '{8'hE1};
        do_write(24'h000010, 0);
        repeat (20) @(negedge clk);
        chk(wel == 1'b1 && rdy == 1'b0, "R10 locked page rejected", {30'b0, wel, rdy}, 32'h2);
        lip = 1'b0;
        bp = 2'b11;
        do_write(24'h000010, 0);
        repeat (20) @(negedge clk);
        chk(wel == 1'b1 && rdy == 1'b0, "R10 full protect rejected", {30'b0, wel, rdy}, 32'h2);

        // R11: protected region boundaries
        bp = 2'b01;
        dq = '{8'hC5};
        do_write(24'h0000C0, 0);
        repeat (20) @(negedge clk);
        chk(rdy == 1'b0, "R11 bp01 offset C0 rejected", {31'b0, rdy}, 32'h0);
        dq = '{8'hB5};
        do_write(24'h0000BF, 0);
        wait_idle();
        set_wel();
        bp = 2'b10;
        dq = '{8'h85};
        do_write(24'h000080, 0);
        repeat (20) @(negedge clk);
        chk(rdy == 1'b0, "R11 bp10 offset 80 rejected", {31'b0, rdy}, 32'h0);
        dq = '{8'h75};
        do_write(24'h00007F, 0);
        wait_idle();
        ipl = 1'b0;
        bp = 2'b00;

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 32'h0);
        chk(fwd_q.size() == 0, "R7 all expected forwards seen", fwd_q.size(), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule